// File: doc/BRIEF.md
# Store Address Generation Unit

This block forms the memory address and the base-register update for a store whose offset comes from a register. It takes the base value and the index value. The index value passes through a full shifter that supports logical left, logical right, arithmetic right, rotate right and a one-bit rotate through the carry flag. The shifted index is then added to the base or subtracted from it. The indexing mode picks what goes to memory and what goes back to the base register. Offset mode sends the sum to memory and leaves the base alone. Pre-indexed mode sends the sum to memory and also writes it to the base. Post-indexed mode sends the untouched base to memory and writes the sum to the base.

The unit also checks the shift and mode combination against the limits of the selected access size and of the instruction form. A compact form allows only small left shifts of an added offset. Every illegal combination is flagged, and the side effects of a flagged store are suppressed. The unit produces byte-lane strobes from the access size and the low address bits. For a paired-word access it also gives the address of the second beat. All results are registered, so each request produces its result one cycle later.

Top module: `stagu_top`

## Requirements
- R1: A request presented with `in_valid_i` high gives `out_valid_o` high on the next cycle, and an idle cycle gives `out_valid_o` low on the next cycle. While reset is applied, `out_valid_o`, `wb_en_o`, `strobe_o` and `illegal_o` are all zero.
- R2: The effective sum is `base_i` plus the shifted index when `subtract_i` is 0, and `base_i` minus the shifted index when `subtract_i` is 1, modulo 2^32.
- R3: The shift kind is encoded as 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right, 4 = rotate through carry. A logical right shift by 32 gives zero. An arithmetic right shift by 32 gives copies of bit 31. Rotate through carry gives `{carry_i, index[31:1]}`.
- R4: In offset mode (`mode_i` = 0), `addr_o` is the sum and `wb_en_o` is 0.
- R5: In pre-indexed mode (`mode_i` = 1), `addr_o` is the sum, `wb_en_o` is 1 and `wb_value_o` equals `addr_o`.
- R6: In post-indexed mode (`mode_i` = 2), `addr_o` is the unmodified base, `wb_en_o` is 1 and `wb_value_o` is the sum.
- R7: In the wide form (`compact_i` = 0), byte (`size_i` = 0) and word (`size_i` = 2) accesses allow logical left by 0..31, logical and arithmetic right by 1..32, rotate right by 1..31, and rotate through carry only with an amount of 0. Any other amount, and any kind code above 4, is illegal.
- R8: Halfword (`size_i` = 1) and paired-word (`size_i` = 3) accesses in the wide form are legal only with logical left by 0.
- R9: In the compact form (`compact_i` = 1), only an added index, logical left by 0..3, offset mode, and sizes other than paired-word are legal. A subtracted index is illegal.
- R10: Mode code 3 is illegal. For an illegal request, `illegal_o` is 1, `wb_en_o` is 0 and `strobe_o` is 0.
- R11: `strobe_o` is `1 << addr_o[1:0]` for a byte. For a halfword it is 4'b0011 or 4'b1100, chosen by `addr_o[1]`. For a word or paired-word it is 4'b1111.
- R12: `addr2_o` equals `addr_o + 4` modulo 2^32 for every valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Request present |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value before shifting |
| shift_kind_i | input | 3 | Shift kind code |
| shift_amt_i | input | 6 | Shift amount |
| subtract_i | input | 1 | 1 subtracts the shifted index |
| mode_i | input | 2 | Indexing mode: 0 offset, 1 pre, 2 post |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 paired-word |
| compact_i | input | 1 | Selects the compact instruction form |
| carry_i | input | 1 | Carry flag for rotate through carry |
| out_valid_o | output | 1 | Result present |
| addr_o | output | 32 | Access address (first beat) |
| addr2_o | output | 32 | Second-beat address |
| wb_en_o | output | 1 | Base writeback enable |
| wb_value_o | output | 32 | New base value |
| strobe_o | output | 4 | Byte-lane strobes |
| illegal_o | output | 1 | Request breaks a legality rule |

## Verification
The three indexing modes are applied with one base and index, so a swap between the memory value and the writeback value shows up as a wrong address or a wrong writeback. Each shift kind is given an operand whose top bit or low bit makes it distinct, so the 32-position end cases can be told apart from a wrapped amount and from a plain shift. These include a zero result against sign fill, and the carry entering at bit 31. The legality tables are probed on both sides of every limit for each size and form. The strobes are swept across all byte offsets, so a lane decoded from the wrong address bits is seen.

// File: rtl/stagu_pkg.sv
package stagu_pkg;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shift_kind_e;

    typedef enum logic [1:0] {
        IDX_OFFSET = 2'd0,
        IDX_PRE    = 2'd1,
        IDX_POST   = 2'd2,
        IDX_RSVD   = 2'd3
    } idx_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DUAL = 2'd3
    } acc_size_e;

endpackage

// File: rtl/stagu_shifter.sv
module stagu_shifter
    import stagu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [2:0]        kind_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] res_o
);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

    logic [DATA_W-1:0] lsl_v, lsr_v, asr_v, ror_v, rrx_v;

    always_comb begin
        // logical left: anything at or past full width empties the word
        if (amt_i >= FULL) lsl_v = '0;
        else               lsl_v = val_i << amt_i;

        // logical right: full width gives zero
        if (amt_i >= FULL) lsr_v = '0;
        else               lsr_v = val_i >> amt_i;

        // arithmetic right: full width gives sign fill
        if (amt_i >= FULL) asr_v = {DATA_W{val_i[DATA_W-1]}};
        else               asr_v = DATA_W'($signed(val_i) >>> amt_i);

        // rotate right: zero or full width leaves the value unchanged
        if (amt_i == '0 || amt_i >= FULL) ror_v = val_i;
        else ror_v = (val_i >> amt_i) | (val_i << (FULL - amt_i));

        // one-bit rotate through carry
        rrx_v = {carry_i, val_i[DATA_W-1:1]};
    end

    always_comb begin
        unique case (kind_i)
            SH_LSL:  res_o = lsl_v;
            SH_LSR:  res_o = lsr_v;
            SH_ASR:  res_o = asr_v;
            SH_ROR:  res_o = ror_v;
            SH_RRX:  res_o = rrx_v;
            default: res_o = val_i;
        endcase
    end

endmodule

// File: rtl/stagu_legal.sv
module stagu_legal
    import stagu_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int AMT_W       = 6,
    parameter int COMPACT_MAX = 3
) (
    input  logic [2:0]       kind_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             subtract_i,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       size_i,
    input  logic             compact_i,
    output logic             illegal_o
);
    localparam logic [AMT_W-1:0] FULL  = AMT_W'(DATA_W);
    localparam logic [AMT_W-1:0] C_MAX = AMT_W'(COMPACT_MAX);

    logic bad_mode, bad_kind, bad_compact, bad_narrow, bad_wide;
    logic narrow_size;

    always_comb begin
        bad_mode    = (mode_i == IDX_RSVD);
        bad_kind    = (kind_i > SH_RRX);
        narrow_size = (size_i == SZ_HALF) || (size_i == SZ_DUAL);

        // compact form: added index, small left shift, no writeback, no pair
        bad_compact = subtract_i
                   || (mode_i != IDX_OFFSET)
                   || (size_i == SZ_DUAL)
                   || (kind_i != SH_LSL)
                   || (amt_i > C_MAX);

        // halfword and pair in wide form: index used unshifted
        bad_narrow  = (kind_i != SH_LSL) || (amt_i != '0);

        // byte and word in wide form: per-kind amount windows
        unique case (kind_i)
            SH_LSL:  bad_wide = (amt_i >= FULL);
            SH_LSR:  bad_wide = (amt_i == '0) || (amt_i > FULL);
            SH_ASR:  bad_wide = (amt_i == '0) || (amt_i > FULL);
            SH_ROR:  bad_wide = (amt_i == '0) || (amt_i >= FULL);
            SH_RRX:  bad_wide = (amt_i != '0);
            default: bad_wide = 1'b1;
        endcase

        if (compact_i)        illegal_o = bad_mode | bad_kind | bad_compact;
        else if (narrow_size) illegal_o = bad_mode | bad_kind | bad_narrow;
        else                  illegal_o = bad_mode | bad_kind | bad_wide;
    end

endmodule

// File: rtl/stagu_lanes.sv
module stagu_lanes
    import stagu_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [$clog2(LANES)-1:0] addr_lo_i,
    input  logic [1:0]               size_i,
    output logic [LANES-1:0]         strobe_o
);
    localparam int LB = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [LB-1:0] LANE_ID = LB'(g);
        always_comb begin
            unique case (size_i)
                SZ_BYTE: strobe_o[g] = (addr_lo_i == LANE_ID);
                SZ_HALF: strobe_o[g] = (addr_lo_i[LB-1:1] == LANE_ID[LB-1:1]);
                default: strobe_o[g] = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/stagu_top.sv
module stagu_top
    import stagu_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int AMT_W       = 6,
    parameter int COMPACT_MAX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] index_i,
    input  logic [2:0]        shift_kind_i,
    input  logic [AMT_W-1:0]  shift_amt_i,
    input  logic              subtract_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        size_i,
    input  logic              compact_i,
    input  logic              carry_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] addr2_o,
    output logic              wb_en_o,
    output logic [DATA_W-1:0] wb_value_o,
    output logic [DATA_W/8-1:0] strobe_o,
    output logic              illegal_o
);
    localparam int LANES = DATA_W / 8;
    localparam int LB    = $clog2(LANES);
    localparam logic [DATA_W-1:0] BEAT_STEP = DATA_W'(LANES);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] addr2;
        logic              wb_en;
        logic [DATA_W-1:0] wb_val;
        logic [LANES-1:0]  strobe;
        logic              illegal;
    } res_t;

    res_t res_d, res_q;

    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] acc_addr;
    logic              bad;
    logic [LANES-1:0]  lane_sel;

    stagu_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
        .val_i   (index_i),
        .kind_i  (shift_kind_i),
        .amt_i   (shift_amt_i),
        .carry_i (carry_i),
        .res_o   (shifted)
    );

    stagu_legal #(.DATA_W(DATA_W), .AMT_W(AMT_W), .COMPACT_MAX(COMPACT_MAX)) u_legal (
        .kind_i     (shift_kind_i),
        .amt_i      (shift_amt_i),
        .subtract_i (subtract_i),
        .mode_i     (mode_i),
        .size_i     (size_i),
        .compact_i  (compact_i),
        .illegal_o  (bad)
    );

    always_comb begin
        sum      = subtract_i ? (base_i - shifted) : (base_i + shifted);
        acc_addr = (mode_i == IDX_POST) ? base_i : sum;
    end

    stagu_lanes #(.LANES(LANES)) u_lanes (
        .addr_lo_i (acc_addr[LB-1:0]),
        .size_i    (size_i),
        .strobe_o  (lane_sel)
    );

    always_comb begin
        res_d = '0;
        if (in_valid_i) begin
            res_d.valid  = 1'b1;
            res_d.addr   = acc_addr;
            res_d.addr2  = acc_addr + BEAT_STEP;
            res_d.wb_val = sum;
            unique case (mode_i)
                IDX_PRE:  res_d.wb_en = 1'b1;
                IDX_POST: res_d.wb_en = 1'b1;
                default:  res_d.wb_en = 1'b0;
            endcase
            res_d.strobe = lane_sel;
            if (bad) begin
                res_d.illegal = 1'b1;
                res_d.wb_en   = 1'b0;
                res_d.strobe  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid_o = res_q.valid;
    assign addr_o      = res_q.addr;
    assign addr2_o     = res_q.addr2;
    assign wb_en_o     = res_q.wb_en;
    assign wb_value_o  = res_q.wb_val;
    assign strobe_o    = res_q.strobe;
    assign illegal_o   = res_q.illegal;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o); // R1

    AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && mode_i == IDX_OFFSET) |=> !wb_en_o); // R4

    AST_PRE_WB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && mode_i == IDX_PRE && !bad) |=> (wb_en_o && wb_value_o == addr_o)); // R5

    AST_POST_ADDR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && mode_i == IDX_POST) |=> (addr_o == $past(base_i))); // R6

    AST_COMPACT_SUB_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && compact_i && subtract_i) |=> illegal_o); // R9

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wb_en_o && strobe_o == '0)); // R10

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && size_i == SZ_BYTE && !bad) |=> ($countones(strobe_o) == 1)); // R11

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (addr2_o == addr_o + BEAT_STEP)); // R12

endmodule

// File: tb/sim_stagu_top.sv
module sim_stagu_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] base = '0;
    logic [31:0] index = '0;
    logic [2:0]  kind = '0;
    logic [5:0]  amt = '0;
    logic        sub = 1'b0;
    logic [1:0]  mode = '0;
    logic [1:0]  size = '0;
    logic        compact = 1'b0;
    logic        carry = 1'b0;

    logic        out_valid;
    logic [31:0] addr, addr2, wb_value;
    logic        wb_en, illegal;
    logic [3:0]  strobe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stagu_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid),
        .base_i(base), .index_i(index), .shift_kind_i(kind),
        .shift_amt_i(amt), .subtract_i(sub), .mode_i(mode),
        .size_i(size), .compact_i(compact), .carry_i(carry),
        .out_valid_o(out_valid), .addr_o(addr), .addr2_o(addr2),
        .wb_en_o(wb_en), .wb_value_o(wb_value), .strobe_o(strobe),
        .illegal_o(illegal)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] model_shift(input logic [31:0] x, input logic [2:0] k, input int n, input logic c);
        logic [63:0] w;
        case (k)
            3'd0: w = {32'd0, x} << n;
            3'd1: w = {32'd0, x} >> n;
            3'd2: w = {{32{x[31]}}, x} >> n;
            3'd3: w = {x, x} >> n;
            default: w = {32'd0, c, x[31:1]};
        endcase
        return w[31:0];
    endfunction

    // apply one request; returns with the registered result visible
    task automatic req(input logic [31:0] b, input logic [31:0] i, input logic [2:0] k, input logic [5:0] a,
                       input logic s, input logic [1:0] m, input logic [1:0] z, input logic cp, input logic c);
        @(negedge clk);
        in_valid = 1'b1; base = b; index = i; kind = k; amt = a;
        sub = s; mode = m; size = z; compact = cp; carry = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "valid in reset", {31'd0, out_valid}, 32'd0);
        chk("R1", "wb_en in reset", {31'd0, wb_en}, 32'd0);
        chk("R1", "strobe in reset", {28'd0, strobe}, 32'd0);
        chk("R1", "illegal in reset", {31'd0, illegal}, 32'd0);
    endtask

    task automatic t_modes;
        req(32'h1000, 32'h20, 3'd0, 6'd2, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0);
        chk("R1", "valid after request", {31'd0, out_valid}, 32'd1);
        chk("R4", "offset addr", addr, 32'h1080);
        chk("R4", "offset wb_en", {31'd0, wb_en}, 32'd0);
        req(32'h1000, 32'h20, 3'd0, 6'd2, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0);
        chk("R5", "pre addr", addr, 32'h1080);
        chk("R5", "pre wb_en", {31'd0, wb_en}, 32'd1);
        chk("R5", "pre wb value", wb_value, 32'h1080);
        req(32'h1000, 32'h20, 3'd0, 6'd2, 1'b0, 2'd2, 2'd2, 1'b0, 1'b0);
        chk("R6", "post addr", addr, 32'h1000);
        chk("R6", "post wb_en", {31'd0, wb_en}, 32'd1);
        chk("R6", "post wb value", wb_value, 32'h1080);
        req(32'h1000, 32'h20, 3'd0, 6'd2, 1'b1, 2'd2, 2'd2, 1'b0, 1'b0);
        chk("R2", "subtract wb value", wb_value, 32'h0F80);
        req(32'h10, 32'h20, 3'd0, 6'd0, 1'b1, 2'd0, 2'd2, 1'b0, 1'b0);
        chk("R2", "subtract wraps", addr, 32'hFFFF_FFF0);
    endtask

    task automatic one_shift(input logic [31:0] x, input logic [2:0] k, input int n, input logic c);
        logic [31:0] e;
        e = model_shift(x, k, n, c);
        req(32'h0, x, k, 6'(n), 1'b0, 2'd0, 2'd2, 1'b0, c);
        chk("R3", $sformatf("shift kind %0d by %0d", k, n), addr, e);
        chk("R3", "legal shift", {31'd0, illegal}, 32'd0);
    endtask

    task automatic t_shifts;
        one_shift(32'h8000_0000, 3'd1, 32, 1'b0);
        one_shift(32'h8000_0000, 3'd2, 32, 1'b0);
        one_shift(32'h7000_0000, 3'd2, 32, 1'b0);
        one_shift(32'h8000_0010, 3'd2, 4, 1'b0);
        one_shift(32'h1234_5678, 3'd3, 8, 1'b0);
        one_shift(32'h1234_5678, 3'd3, 31, 1'b0);
        one_shift(32'h0000_0002, 3'd4, 0, 1'b1);
        one_shift(32'h0000_0003, 3'd4, 0, 1'b0);
        one_shift(32'h0000_0003, 3'd0, 31, 1'b0);
        one_shift(32'hF000_000F, 3'd1, 1, 1'b0);
    endtask

    task automatic expect_bad(input string r, input string what, input logic bad_exp);
        chk(r, what, {31'd0, illegal}, {31'd0, bad_exp});
        if (bad_exp) begin
            chk("R10", {what, " wb_en"}, {31'd0, wb_en}, 32'd0);
            chk("R10", {what, " strobe"}, {28'd0, strobe}, 32'd0);
        end
    endtask

    task automatic t_wide_limits;
        req(32'h0, 32'h1, 3'd1, 6'd0, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0); expect_bad("R7", "LSR 0", 1'b1);
        req(32'h0, 32'h1, 3'd2, 6'd33, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0); expect_bad("R7", "ASR 33", 1'b1);
        req(32'h0, 32'h1, 3'd3, 6'd32, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0); expect_bad("R7", "ROR 32", 1'b1);
        req(32'h0, 32'h1, 3'd0, 6'd32, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0); expect_bad("R7", "LSL 32", 1'b1);
        req(32'h0, 32'h1, 3'd4, 6'd1, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0); expect_bad("R7", "RRX amount 1", 1'b1);
        req(32'h0, 32'h1, 3'd5, 6'd0, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0); expect_bad("R7", "kind 5", 1'b1);
        req(32'h0, 32'h1, 3'd3, 6'd1, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0); expect_bad("R7", "ROR 1 byte", 1'b0);
        req(32'h0, 32'h1, 3'd1, 6'd32, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0); expect_bad("R7", "LSR 32 byte", 1'b0);
        req(32'h0, 32'h1, 3'd0, 6'd0, 1'b0, 2'd3, 2'd2, 1'b0, 1'b0); expect_bad("R10", "mode 3", 1'b1);
    endtask

    task automatic t_half_dual;
        req(32'h100, 32'h2, 3'd0, 6'd0, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0); expect_bad("R8", "half LSL 0", 1'b0);
        chk("R8", "half subtract addr", addr, 32'hFE);
        req(32'h100, 32'h2, 3'd0, 6'd1, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0); expect_bad("R8", "half LSL 1", 1'b1);
        req(32'h100, 32'h2, 3'd1, 6'd1, 1'b0, 2'd1, 2'd3, 1'b0, 1'b0); expect_bad("R8", "pair LSR 1", 1'b1);
        req(32'h100, 32'h2, 3'd0, 6'd0, 1'b0, 2'd2, 2'd3, 1'b0, 1'b0); expect_bad("R8", "pair LSL 0", 1'b0);
    endtask

    task automatic t_compact;
        req(32'h40, 32'h1, 3'd0, 6'd3, 1'b0, 2'd0, 2'd2, 1'b1, 1'b0); expect_bad("R9", "compact LSL 3", 1'b0);
        chk("R9", "compact addr", addr, 32'h48);
        req(32'h40, 32'h1, 3'd0, 6'd4, 1'b0, 2'd0, 2'd2, 1'b1, 1'b0); expect_bad("R9", "compact LSL 4", 1'b1);
        req(32'h40, 32'h1, 3'd0, 6'd1, 1'b1, 2'd0, 2'd2, 1'b1, 1'b0); expect_bad("R9", "compact subtract", 1'b1);
        req(32'h40, 32'h1, 3'd0, 6'd1, 1'b0, 2'd1, 2'd2, 1'b1, 1'b0); expect_bad("R9", "compact pre", 1'b1);
        req(32'h40, 32'h1, 3'd0, 6'd0, 1'b0, 2'd0, 2'd3, 1'b1, 1'b0); expect_bad("R9", "compact pair", 1'b1);
        req(32'h40, 32'h1, 3'd1, 6'd1, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0); expect_bad("R9", "compact LSR", 1'b1);
        req(32'h40, 32'h1, 3'd0, 6'd2, 1'b0, 2'd0, 2'd1, 1'b1, 1'b0); expect_bad("R9", "compact half", 1'b0);
    endtask

    task automatic t_strobes;
        for (int off = 0; off < 4; off++) begin
            req(32'h200 + 32'(off), 32'h0, 3'd0, 6'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0);
            chk("R11", $sformatf("byte lane %0d", off), {28'd0, strobe}, 32'(4'b0001 << off));
        end
        req(32'h202, 32'h0, 3'd0, 6'd0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0);
        chk("R11", "half upper", {28'd0, strobe}, 32'hC);
        req(32'h200, 32'h0, 3'd0, 6'd0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0);
        chk("R11", "half lower", {28'd0, strobe}, 32'h3);
        req(32'h203, 32'h0, 3'd0, 6'd0, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0);
        chk("R11", "post byte uses base", {28'd0, strobe}, 32'h8);
        req(32'h200, 32'h0, 3'd0, 6'd0, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0);
        chk("R11", "word lanes", {28'd0, strobe}, 32'hF);
    endtask

    task automatic t_pair;
        req(32'h2000, 32'h8, 3'd0, 6'd0, 1'b0, 2'd1, 2'd3, 1'b0, 1'b0);
        chk("R12", "pair first", addr, 32'h2008);
        chk("R12", "pair second", addr2, 32'h200C);
        chk("R11", "pair lanes", {28'd0, strobe}, 32'hF);
        req(32'hFFFF_FFF8, 32'h4, 3'd0, 6'd0, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0);
        chk("R12", "pair second wraps", addr2, 32'h0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1", "idle gives no valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "idle gives no wb", {31'd0, wb_en}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_modes();
        t_shifts();
        t_wide_limits();
        t_half_dual();
        t_compact();
        t_strobes();
        t_pair();
        t_idle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule